// File: doc/BRIEF.md
# 16-bit Event Timer

This block is a 16-bit up-counter with one comparator and one toggle output, controlled through a small single-cycle register port. The counter advances either on every clock while running, or on rising, falling or both edges of one trigger line picked from sixteen external inputs. Each trigger line is synchronised with two flops before edge detection. The counter reports two events: a wrap from all ones to zero, and a step into the value held in the comparator. Each event latches a status flag. A flag drives the interrupt line when its enable bit is set. Either event can also flip the timer output, and a compare event can restart the count from zero.

The counter and the comparator have no addresses of their own. Software loads and reads both through one shared 16-bit data register, using four command bits in the control word. Each command bit clears itself once its transfer is done. The control and status registers each have a set alias and a clear alias, where every written 1 sets or clears the matching bit. A debug-halt input can freeze the counter when a control bit permits it.

Top module: `evt_timer16`

## Requirements
- R1: After reset, the control, data and status registers read 0, `irq` is 0 and `tmr_out` is 0.
- R2: With count mode 0 (control bits 1:0), the counter advances by one on every clock edge at which the run bit (control bit 31) is set.
- R3: Count modes 1, 2 and 3 advance the counter on rising, falling and both edges of the trigger line selected by control bits 7:4. Edges on any other line have no effect.
- R4: The data register sits in bits 15:0 at address 0x10. A 1 written to control bit 8 loads the counter from it, bit 9 copies the counter into it, bit 10 loads the comparator from it, and bit 11 copies the comparator into it.
- R5: Each of control bits 8 to 11 reads back as 0 once its transfer has taken place, which is one clock after it was set.
- R6: A count step from 0xFFFF to 0x0000 sets status bit 0.
- R7: A count step into the comparator value sets status bit 1. `irq` equals (status bit 0 AND control bit 16) OR (status bit 1 AND control bit 17).
- R8: With control bit 18 set, each overflow inverts `tmr_out`. With control bit 19 set, each compare event inverts it. With both clear, `tmr_out` holds.
- R9: With control bit 24 set, the count step after a compare event goes to 0 instead of incrementing, so the counter cycles through comparator+1 values.
- R10: With the run bit clear, the counter holds its value and no overflow or compare flag is raised.
- R11: With control bit 30 set, the counter holds while `dbg_halt` is high. With bit 30 clear, `dbg_halt` has no effect.
- R12: The control register is at 0x00, its set alias at 0x04 and its clear alias at 0x08. The status register is at 0x20, its set alias at 0x24 and its clear alias at 0x28. A write to the base address replaces the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_in | input | 16 | Asynchronous external trigger lines |
| dbg_halt | input | 1 | Debug-halt request |
| tmr_out | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the exact step counts and the wrap and compare events. The counter is visible only through a capture command, and it keeps moving while it runs. The bench therefore opens a run window with one control write and closes it with one clear-alias write a known number of idle cycles later, which gives an exact step count. It then captures the frozen counter. It preloads values such as 0xFFFE and 0xFFFF through the data register to land overflow, compare and compare-reset on known steps. It drives trigger pulses on chosen lines, both selected and unselected, to exercise each edge mode.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

    localparam int CNT_W  = 16;
    localparam int TRIG_N = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;

    // control word bit positions (software-visible layout)
    localparam int B_MODE_LO = 0;
    localparam int B_SEL_LO  = 4;
    localparam int B_LDCNT   = 8;
    localparam int B_RDCNT   = 9;
    localparam int B_LDCMP   = 10;
    localparam int B_RDCMP   = 11;
    localparam int B_IE_OVF  = 16;
    localparam int B_IE_CMP  = 17;
    localparam int B_TG_OVF  = 18;
    localparam int B_TG_CMP  = 19;
    localparam int B_CMPRST  = 24;
    localparam int B_DBGSTOP = 30;
    localparam int B_RUN     = 31;

    // status bit positions
    localparam int S_OVF = 0;
    localparam int S_CMP = 1;

    // register byte addresses
    localparam int A_CTRL = 'h00;
    localparam int A_CSET = 'h04;
    localparam int A_CCLR = 'h08;
    localparam int A_DATA = 'h10;
    localparam int A_STAT = 'h20;
    localparam int A_SSET = 'h24;
    localparam int A_SCLR = 'h28;

    typedef enum logic [1:0] {
        MODE_CLK  = 2'd0,
        MODE_RISE = 2'd1,
        MODE_FALL = 2'd2,
        MODE_BOTH = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/evt_timer16_trigsync.sv
module evt_timer16_trigsync
    import evt_timer16_pkg::*;
#(
    parameter int TRIG_N = 16,
    parameter int SEL_W  = $clog2(TRIG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    input  cnt_mode_e         mode,
    output logic              step
);

    logic [TRIG_N-1:0] stab;

    // two-flop synchroniser per trigger line
    for (genvar i = 0; i < TRIG_N; i++) begin : g_sync
        logic meta_q, meta_d;
        logic hold_q, hold_d;

        always_comb begin
            meta_d = trig_in[i];
            hold_d = meta_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= meta_d;
                hold_q <= hold_d;
            end
        end

        assign stab[i] = hold_q;
    end

    logic cur;
    logic prev_q, prev_d;

    always_comb begin
        cur    = stab[sel];
        prev_d = cur;
        unique case (mode)
            MODE_CLK:  step = 1'b1;
            MODE_RISE: step = cur & ~prev_q;
            MODE_FALL: step = ~cur & prev_q;
            MODE_BOTH: step = cur ^ prev_q;
            default:   step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R3: in an edge mode, a step requires a change on the selected line
    a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_CLK && cur == prev_q) |-> !step);

endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             step,
    input  logic             ld_cnt,
    input  logic             ld_cmp,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             cmp_rst_en,
    input  logic             tog_ovf,
    input  logic             tog_cmp,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cmp_val,
    output logic             ovf_ev,
    output logic             cmp_ev,
    output logic             tmr_out
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             pend;
        logic             out;
    } core_t;

    core_t q, d;
    logic             adv;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        d      = q;
        adv    = cnt_en & step;
        nxt    = q.pend ? '0 : q.cnt + 1'b1;
        ovf_ev = 1'b0;
        cmp_ev = 1'b0;
        if (ld_cnt) begin
            d.cnt  = ld_val;
            d.pend = 1'b0;
        end else if (adv) begin
            d.cnt  = nxt;
            d.pend = 1'b0;
            ovf_ev = ~q.pend & (&q.cnt);
            if (nxt == q.cmp) begin
                cmp_ev = 1'b1;
                d.pend = cmp_rst_en;
            end
        end
        if (ld_cmp) d.cmp = ld_val;
        d.out = q.out ^ (ovf_ev & tog_ovf) ^ (cmp_ev & tog_cmp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_val = q.cnt;
    assign cmp_val = q.cmp;
    assign tmr_out = q.out;

    a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ld_cnt) |=> $stable(cnt_val));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_cnt && !q.pend && (&cnt_val)) |=> (cnt_val == '0));

    a_r9_restart_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_cnt && q.pend) |=> (cnt_val == '0));

    a_r8_out_holds_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_ev || cmp_ev) |=> $stable(tmr_out));

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
#(
    parameter int CNT_W  = evt_timer16_pkg::CNT_W,
    parameter int TRIG_N = evt_timer16_pkg::TRIG_N,
    parameter int ADDR_W = evt_timer16_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic              dbg_halt,
    output logic              tmr_out,
    output logic              irq
);

    localparam int SEL_W = $clog2(TRIG_N);
    localparam logic [BUS_W-1:0] CTRL_WMASK =
          (BUS_W'(3) << B_MODE_LO)
        | (BUS_W'((1 << SEL_W) - 1) << B_SEL_LO)
        | (BUS_W'(4'hF) << B_LDCNT)
        | (BUS_W'(4'hF) << B_IE_OVF)
        | (BUS_W'(1) << B_CMPRST)
        | (BUS_W'(1) << B_DBGSTOP)
        | (BUS_W'(1) << B_RUN);

    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic [CNT_W-1:0] data;
        logic [1:0]       stat;
    } regs_t;

    regs_t q, d;
    logic             wr;
    logic             step, cnt_en, ovf_ev, cmp_ev;
    logic [CNT_W-1:0] cnt_val, cmp_val;
    logic [BUS_W-1:0] wmask;

    evt_timer16_trigsync #(
        .TRIG_N (TRIG_N),
        .SEL_W  (SEL_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (q.ctrl[B_SEL_LO +: SEL_W]),
        .mode    (cnt_mode_e'(q.ctrl[B_MODE_LO +: 2])),
        .step    (step)
    );

    assign cnt_en = q.ctrl[B_RUN] & ~(q.ctrl[B_DBGSTOP] & dbg_halt);

    evt_timer16_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .step       (step),
        .ld_cnt     (q.ctrl[B_LDCNT]),
        .ld_cmp     (q.ctrl[B_LDCMP]),
        .ld_val     (q.data),
        .cmp_rst_en (q.ctrl[B_CMPRST]),
        .tog_ovf    (q.ctrl[B_TG_OVF]),
        .tog_cmp    (q.ctrl[B_TG_CMP]),
        .cnt_val    (cnt_val),
        .cmp_val    (cmp_val),
        .ovf_ev     (ovf_ev),
        .cmp_ev     (cmp_ev),
        .tmr_out    (tmr_out)
    );

    always_comb begin
        d     = q;
        wr    = bus_sel & bus_wr;
        wmask = bus_wdata & CTRL_WMASK;
        // command bits are single-shot: cleared after their transfer cycle
        d.ctrl[B_RDCMP:B_LDCNT] = '0;
        if (wr) begin
            case (bus_addr)
                ADDR_W'(A_CTRL): d.ctrl = wmask;
                ADDR_W'(A_CSET): d.ctrl = d.ctrl | wmask;
                ADDR_W'(A_CCLR): d.ctrl = d.ctrl & ~wmask;
                ADDR_W'(A_DATA): d.data = bus_wdata[CNT_W-1:0];
                ADDR_W'(A_STAT): d.stat = bus_wdata[1:0];
                ADDR_W'(A_SSET): d.stat = d.stat | bus_wdata[1:0];
                ADDR_W'(A_SCLR): d.stat = d.stat & ~bus_wdata[1:0];
                default: ;
            endcase
        end
        // captures override a same-cycle bus write to the data register
        if (q.ctrl[B_RDCMP]) d.data = cmp_val;
        if (q.ctrl[B_RDCNT]) d.data = cnt_val;
        // hardware events win over a same-cycle software clear
        d.stat[S_OVF] = d.stat[S_OVF] | ovf_ev;
        d.stat[S_CMP] = d.stat[S_CMP] | cmp_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(A_CTRL), ADDR_W'(A_CSET), ADDR_W'(A_CCLR): bus_rdata = q.ctrl;
            ADDR_W'(A_DATA): bus_rdata = BUS_W'(q.data);
            ADDR_W'(A_STAT), ADDR_W'(A_SSET), ADDR_W'(A_SCLR): bus_rdata = BUS_W'(q.stat);
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (q.stat[S_OVF] & q.ctrl[B_IE_OVF]) | (q.stat[S_CMP] & q.ctrl[B_IE_CMP]);

    a_r5_load_cmd_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[B_LDCNT] && !(wr && (bus_addr == ADDR_W'(A_CTRL) || bus_addr == ADDR_W'(A_CSET))
                              && bus_wdata[B_LDCNT]))
        |=> !q.ctrl[B_LDCNT]);

    a_r12_status_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(A_SCLR) && bus_wdata[S_OVF] && !ovf_ev) |=> !q.stat[S_OVF]);

    a_r4_capture_counter: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl[B_RDCNT] |=> (q.data == $past(cnt_val)));

endmodule

// File: tb/evt_timer16_tb_top.sv
module evt_timer16_tb_top;

    localparam int CLK_P = 10;

    localparam logic [5:0] A_CTRL = 6'h00, A_CSET = 6'h04, A_CCLR = 6'h08, A_DATA = 6'h10,
                           A_STAT = 6'h20, A_SSET = 6'h24, A_SCLR = 6'h28;
    localparam logic [31:0] RUN = 32'h8000_0000, DBGSTOP = 32'h4000_0000, CMPRST = 32'h0100_0000,
                            TG_CMP = 32'h0008_0000, TG_OVF = 32'h0004_0000,
                            IE_CMP = 32'h0002_0000, IE_OVF = 32'h0001_0000;

    // edge-mode vectors: [29:28] mode, [27:24] select, [23:20] driven line,
    // [19:16] pulses, [15:0] expected count
    localparam logic [29:0] VEC [7] = '{
        {2'd1, 4'd3,  4'd3,  4'd5, 16'd5},
        {2'd2, 4'd3,  4'd3,  4'd4, 16'd4},
        {2'd3, 4'd7,  4'd7,  4'd3, 16'd6},
        {2'd1, 4'd0,  4'd0,  4'd1, 16'd1},
        {2'd1, 4'd15, 4'd15, 4'd6, 16'd6},
        {2'd3, 4'd9,  4'd2,  4'd5, 16'd0},
        {2'd2, 4'd12, 4'd12, 4'd2, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] trig_in = '0;
    logic        dbg_halt = 1'b0;
    logic        tmr_out, irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    evt_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
        .dbg_halt(dbg_halt), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        bus_write(A_DATA, {16'h0, v});
        bus_write(A_CSET, 32'h100);
        idle(1);
    endtask

    task automatic load_cmp(input logic [15:0] v);
        bus_write(A_DATA, {16'h0, v});
        bus_write(A_CSET, 32'h400);
        idle(1);
    endtask

    task automatic cap(input logic [31:0] cmd, output logic [31:0] v);
        bus_write(A_CSET, cmd);
        idle(1);
        bus_read(A_DATA, v);
    endtask

    // opens a run window of exactly w+1 count steps
    task automatic run_window(input logic [31:0] ctl, input int w);
        bus_write(A_CTRL, ctl);
        idle(w);
        bus_write(A_CCLR, RUN);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        bus_read(A_DATA, v); chk("R1 data", v, 32'h0);
        bus_read(A_STAT, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 tmr_out", {31'h0, tmr_out}, 32'h0);

        // R4 data path for comparator and counter
        load_cmp(16'h1234);
        bus_write(A_DATA, 32'hABCD);
        cap(32'h800, v); chk("R4 comparator readback", v, 32'h1234);
        load_cnt(16'hBEEF);
        bus_write(A_DATA, 32'h0);
        cap(32'h200, v); chk("R4 counter readback", v, 32'hBEEF);
        // R5 command bits self-clear
        bus_read(A_CTRL, v); chk("R5 command bits clear", v & 32'hF00, 32'h0);

        // R2 free-running count
        load_cmp(16'h8000);
        load_cnt(16'h0);
        run_window(RUN, 20);
        cap(32'h200, v); chk("R2 free count 21 steps", v, 32'd21);

        // R3 edge modes from the vector table
        foreach (VEC[i]) begin
            bus_write(A_CTRL, 32'h0);
            load_cnt(16'h0);
            bus_write(A_CTRL, RUN | {24'h0, VEC[i][27:24], 2'b00, VEC[i][29:28]});
            for (int p = 0; p < int'(VEC[i][19:16]); p++) begin
                trig_in[VEC[i][23:20]] = 1'b1; idle(3);
                trig_in[VEC[i][23:20]] = 1'b0; idle(3);
            end
            idle(4);
            bus_write(A_CCLR, RUN);
            cap(32'h200, v);
            chk($sformatf("R3 edge vector %0d", i), v, {16'h0, VEC[i][15:0]});
        end
        bus_write(A_CTRL, 32'h0);
        bus_write(A_STAT, 32'h0);

        // R6 overflow, R7 interrupt gating, R12 status aliases
        load_cnt(16'hFFFE);
        run_window(RUN, 1);
        cap(32'h200, v); chk("R6 counter wrapped", v, 32'h0);
        bus_read(A_STAT, v); chk("R6 overflow flag", v, 32'h1);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        chk("R8 no toggle when disabled", {31'h0, tmr_out}, 32'h0);
        bus_write(A_CSET, IE_OVF);
        bus_read(A_STAT, v);
        chk("R7 irq from overflow", {31'h0, irq}, 32'h1);
        bus_write(A_SCLR, 32'h1);
        bus_read(A_STAT, v); chk("R12 status clear alias", v, 32'h0);
        chk("R7 irq dropped", {31'h0, irq}, 32'h0);
        bus_write(A_CSET, IE_CMP);
        bus_write(A_SSET, 32'h2);
        bus_read(A_STAT, v); chk("R12 status set alias", v, 32'h2);
        chk("R7 irq from compare flag", {31'h0, irq}, 32'h1);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R12 status base write", v, 32'h0);

        // R12 control aliases
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CSET, 32'h000F_0031);
        bus_read(A_CTRL, v); chk("R12 control set alias", v, 32'h000F_0031);
        bus_write(A_CCLR, 32'h0005_0010);
        bus_read(A_CTRL, v); chk("R12 control clear alias", v, 32'h000A_0021);
        bus_write(A_CTRL, 32'h0);

        // R7/R8 compare event with toggle
        load_cmp(16'd5);
        load_cnt(16'd0);
        run_window(RUN | TG_CMP | IE_CMP, 4);
        bus_read(A_STAT, v); chk("R7 compare flag", v, 32'h2);
        chk("R7 irq on compare", {31'h0, irq}, 32'h1);
        chk("R8 toggle on compare", {31'h0, tmr_out}, 32'h1);

        // R8 toggle on overflow
        bus_write(A_STAT, 32'h0);
        load_cmp(16'h8000);
        load_cnt(16'hFFFF);
        run_window(RUN | TG_OVF, 0);
        bus_read(A_STAT, v); chk("R6 overflow from 0xFFFF", v, 32'h1);
        chk("R8 toggle on overflow", {31'h0, tmr_out}, 32'h0);
        chk("R7 irq off with enables clear", {31'h0, irq}, 32'h0);

        // R9 compare reset: period of cmp+1
        bus_write(A_STAT, 32'h0);
        load_cmp(16'd3);
        load_cnt(16'd0);
        run_window(RUN | CMPRST, 9);
        cap(32'h200, v); chk("R9 compare reset count", v, 32'd2);

        // R10 stopped timer holds and raises no flag
        bus_write(A_CTRL, 32'h0);
        bus_write(A_STAT, 32'h0);
        load_cmp(16'd8);
        load_cnt(16'd7);
        idle(10);
        cap(32'h200, v); chk("R10 stopped counter holds", v, 32'd7);
        bus_read(A_STAT, v); chk("R10 no flags when stopped", v, 32'h0);

        // R11 debug halt
        load_cmp(16'h8000);
        load_cnt(16'd0);
        dbg_halt = 1'b1;
        run_window(RUN | DBGSTOP, 4);
        cap(32'h200, v); chk("R11 frozen in debug halt", v, 32'd0);
        run_window(RUN, 5);
        cap(32'h200, v); chk("R11 halt ignored when bit 30 clear", v, 32'd6);
        dbg_halt = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule